// File: doc/BRIEF.md
# Model-Following PID Adapter for Fuzzy Output Centers

This block adapts the output-set centers of a fuzzy speed controller. On every sample strobe it advances a discrete second-order reference model driven by the speed command. It subtracts the measured speed from the model output to get a model-following error. A discrete PID law on that error gives a signed adaptation factor. The factor is then added to the stored center of each fuzzy rule that was active in the previous sample. Centers of all other rules keep their values.

The five model coefficients and the three gains are signed Q8.8 values in a small bank. The bank can be loaded only while the block is idle. The center table sits outside the block. The block reads a center through a combinational read port and writes the updated value back through a valid/ready write channel. Each write is held until the table accepts it, so the table may apply back-pressure for any number of cycles. The default sample rate is 20 Hz from a 50 MHz clock, which is one strobe every 2,500,000 cycles. At most four writes follow each strobe, so back-pressure has ample time to clear before the next sample.

Top module: `adp_center_adapter`

## Requirements
- R1: After reset, `busy`, `model_out`, `adapt_out` and `cen_wr_valid` are all zero. The model history, the error history and the error accumulator are also cleared, and no rule list is held.
- R2: On an accepted strobe, the block computes ym = sat16(floor((a0·x + a1·x1 + a2·x2 − b1·y1 − b2·y2) / 256)) and registers it on `model_out`. Here x is `speed_cmd`, x1 and x2 are the commands of the two previous accepted strobes, and y1 and y2 are the two previous model outputs. All coefficients are signed Q8.8.
- R3: On an accepted strobe, the error is ye = sat16(ym − `speed_meas`) and its change is dye = ye − ye_prev. `adapt_out` becomes sat16(floor((Kp·ye + Ki·S + Kd·dye) / 256)). S is the error sum of the earlier samples only, so the current sample is not included.
- R4: The error sum S saturates at +32767 and −32768. It never wraps.
- R5: A strobe latches the rule list (`act_vld`, `act_idx`). Writes after a strobe go only to the rules of the list latched by the previous accepted strobe. The first strobe after reset causes no write. Slots whose valid bit is 0 produce no write, and no other table entry changes.
- R6: The block writes in slot order 0 to 3. Each written value is sat16(center + `adapt_out`), using the center read at that rule's index.
- R7: While `cen_wr_valid` is high and `cen_wr_ready` is low, `cen_wr_valid` stays high and `cen_wr_addr` stays unchanged.
- R8: A `cfg_we` write stores `cfg_data` in the coefficient picked by `cfg_sel`: 0 a0, 1 a1, 2 a2, 3 b1, 4 b2, 5 Kp, 6 Ki, 7 Kd. The write takes effect only when `busy` is low and `sample_stb` is low in the same cycle. Otherwise it is ignored.
- R9: A strobe that arrives while `busy` is high is ignored. The model, the PID state, the outputs and the latched list are left unchanged.
- R10: Reset loads these coefficients: a0=2, a1=4, a2=2, b1=−417, b2=170, Kp=998, Ki=1708, Kd=146 (all in Q8.8).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_stb | input | 1 | One-cycle sample strobe |
| speed_cmd | input | 16 | Signed speed command |
| speed_meas | input | 16 | Signed measured speed |
| act_vld | input | 4 | Valid bit of each active-rule slot |
| act_idx | input | 24 | Rule index of each slot, slot i at bits [6i+5:6i] |
| cfg_we | input | 1 | Coefficient write enable |
| cfg_sel | input | 3 | Coefficient select |
| cfg_data | input | 16 | Signed Q8.8 coefficient value |
| busy | output | 1 | Write phase in progress |
| model_out | output | 16 | Latest reference-model output |
| adapt_out | output | 16 | Latest adaptation factor |
| cen_rd_addr | output | 6 | Center table read index |
| cen_rd_data | input | 16 | Center value at `cen_rd_addr`, same cycle |
| cen_wr_valid | output | 1 | Center write request |
| cen_wr_ready | input | 1 | Table accepts the write |
| cen_wr_addr | output | 6 | Rule index being written |
| cen_wr_data | output | 16 | Updated center value |

## Verification
Two functions can meet in one cycle: a coefficient write and a sample strobe. The bench asserts `cfg_we` with a zero Kp in the same cycle as an accepted strobe. It then checks that the adaptation factor still matches a model that kept the old Kp. A second case keeps the write phase stalled by holding `cen_wr_ready` low, then issues both a coefficient write and a strobe. The checks are that the held write keeps its address, that model and factor outputs do not move, and that the results after release follow the unchanged coefficient bank.

// File: rtl/adp_pkg.sv
package adp_pkg;
  localparam int DW = 16;   // data width of speeds, centers, factor
  localparam int CW = 16;   // coefficient width
  localparam int QF = 8;    // fractional bits of coefficients
  localparam int SW = 48;   // width of internal sums of products
  localparam int NCOEF = 8;

  typedef enum logic [2:0] {
    SEL_A0 = 3'd0, SEL_A1 = 3'd1, SEL_A2 = 3'd2, SEL_B1 = 3'd3,
    SEL_B2 = 3'd4, SEL_KP = 3'd5, SEL_KI = 3'd6, SEL_KD = 3'd7
  } coef_sel_e;

  typedef enum logic { WR_IDLE = 1'b0, WR_RUN = 1'b1 } wr_state_e;

  function automatic logic signed [DW-1:0] sat_dw(input logic signed [SW-1:0] v);
    logic signed [SW-1:0] hi;
    logic signed [SW-1:0] lo;
    hi = SW'((2 ** (DW - 1)) - 1);
    lo = -SW'(2 ** (DW - 1));
    if (v > hi)      return hi[DW-1:0];
    else if (v < lo) return lo[DW-1:0];
    else             return v[DW-1:0];
  endfunction
endpackage

// File: rtl/adp_coef_bank.sv
module adp_coef_bank
  import adp_pkg::*;
#(
  parameter logic [NCOEF*CW-1:0] DEFAULTS = '0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   lock,
  input  logic                   we,
  input  logic [2:0]             sel,
  input  logic signed [CW-1:0]   data,
  output logic [NCOEF*CW-1:0]    bank
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank <= DEFAULTS;
    end else if (we && !lock) begin
      bank[sel*CW +: CW] <= data;
    end
  end

  // R8: while the bank is locked nothing in it may change
  p_cfg_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> $stable(bank));
endmodule

// File: rtl/adp_refmodel.sv
module adp_refmodel
  import adp_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  step,
  input  logic signed [DW-1:0]  x_in,
  input  logic signed [CW-1:0]  a0,
  input  logic signed [CW-1:0]  a1,
  input  logic signed [CW-1:0]  a2,
  input  logic signed [CW-1:0]  b1,
  input  logic signed [CW-1:0]  b2,
  output logic signed [DW-1:0]  ym_next,
  output logic signed [DW-1:0]  ym_q
);
  logic signed [DW-1:0] x1, x2, y1, y2;
  logic signed [SW-1:0] acc;

  always_comb begin
    acc = SW'(a0) * SW'(x_in) + SW'(a1) * SW'(x1) + SW'(a2) * SW'(x2)
        - SW'(b1) * SW'(y1) - SW'(b2) * SW'(y2);
    ym_next = sat_dw(acc >>> QF);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x1 <= '0; x2 <= '0; y1 <= '0; y2 <= '0;
    end else if (step) begin
      x2 <= x1;
      x1 <= x_in;
      y2 <= y1;
      y1 <= ym_next;
    end
  end

  assign ym_q = y1;

  // R2: the model output moves only on an accepted step
  p_model_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(ym_q));
endmodule

// File: rtl/adp_pid.sv
module adp_pid
  import adp_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  step,
  input  logic signed [DW-1:0]  ym,
  input  logic signed [DW-1:0]  meas,
  input  logic signed [CW-1:0]  kp,
  input  logic signed [CW-1:0]  ki,
  input  logic signed [CW-1:0]  kd,
  output logic signed [DW-1:0]  p_q
);
  logic signed [DW-1:0] ye, ye_prev, err_sum, err_sum_next, p_next;
  logic signed [SW-1:0] dye, law;

  always_comb begin
    ye           = sat_dw(SW'(ym) - SW'(meas));
    dye          = SW'(ye) - SW'(ye_prev);
    law          = SW'(kp) * SW'(ye) + SW'(ki) * SW'(err_sum) + SW'(kd) * dye;
    p_next       = sat_dw(law >>> QF);
    err_sum_next = sat_dw(SW'(err_sum) + SW'(ye));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ye_prev <= '0;
      err_sum <= '0;
      p_q     <= '0;
    end else if (step) begin
      ye_prev <= ye;
      err_sum <= err_sum_next;
      p_q     <= p_next;
    end
  end

  // R3: the factor is updated only on an accepted step
  p_adapt_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(p_q));
endmodule

// File: rtl/adp_writer.sv
module adp_writer
  import adp_pkg::*;
#(
  parameter int MAXACT = 4,
  parameter int IDXW   = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [MAXACT-1:0]        new_vld,
  input  logic [MAXACT*IDXW-1:0]   new_idx,
  input  logic signed [DW-1:0]     adapt,
  output logic [IDXW-1:0]          rd_addr,
  input  logic signed [DW-1:0]     rd_data,
  output logic                     wr_valid,
  input  logic                     wr_ready,
  output logic [IDXW-1:0]          wr_addr,
  output logic signed [DW-1:0]     wr_data,
  output logic                     busy
);
  localparam int PW = (MAXACT > 1) ? $clog2(MAXACT) : 1;
  localparam logic [PW-1:0] LAST = PW'(MAXACT - 1);

  wr_state_e               st;
  logic [PW-1:0]           ptr;
  logic [MAXACT-1:0]       prev_vld, wk_vld;
  logic [MAXACT*IDXW-1:0]  prev_idx, wk_idx;
  logic                    slot_done;

  assign wr_addr   = wk_idx[ptr*IDXW +: IDXW];
  assign rd_addr   = wr_addr;
  assign wr_valid  = (st == WR_RUN) && wk_vld[ptr];
  assign wr_data   = sat_dw(SW'(rd_data) + SW'(adapt));
  assign busy      = (st == WR_RUN);
  assign slot_done = !wk_vld[ptr] || wr_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= WR_IDLE;
      ptr      <= '0;
      prev_vld <= '0;
      prev_idx <= '0;
      wk_vld   <= '0;
      wk_idx   <= '0;
    end else if (start) begin
      wk_vld   <= prev_vld;
      wk_idx   <= prev_idx;
      prev_vld <= new_vld;
      prev_idx <= new_idx;
      ptr      <= '0;
      st       <= WR_RUN;
    end else if (st == WR_RUN && slot_done) begin
      if (ptr == LAST) st <= WR_IDLE;
      else             ptr <= ptr + 1'b1;
    end
  end

  // R7: a refused write is held with the same address
  p_hold_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr));
endmodule

// File: rtl/adp_center_adapter.sv
module adp_center_adapter
  import adp_pkg::*;
#(
  parameter int NRULES = 49,
  parameter int MAXACT = 4,
  parameter int IDXW   = $clog2(NRULES),
  parameter logic [NCOEF*CW-1:0] COEF_RESET =
    {16'sd146, 16'sd1708, 16'sd998, 16'sd170, -16'sd417, 16'sd2, 16'sd4, 16'sd2}
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sample_stb,
  input  logic signed [DW-1:0]     speed_cmd,
  input  logic signed [DW-1:0]     speed_meas,
  input  logic [MAXACT-1:0]        act_vld,
  input  logic [MAXACT*IDXW-1:0]   act_idx,
  input  logic                     cfg_we,
  input  logic [2:0]               cfg_sel,
  input  logic signed [CW-1:0]     cfg_data,
  output logic                     busy,
  output logic signed [DW-1:0]     model_out,
  output logic signed [DW-1:0]     adapt_out,
  output logic [IDXW-1:0]          cen_rd_addr,
  input  logic signed [DW-1:0]     cen_rd_data,
  output logic                     cen_wr_valid,
  input  logic                     cen_wr_ready,
  output logic [IDXW-1:0]          cen_wr_addr,
  output logic signed [DW-1:0]     cen_wr_data
);
  logic [NCOEF*CW-1:0]  bank;
  logic                 step;
  logic signed [DW-1:0] ym_next;

  assign step = sample_stb && !busy;

  adp_coef_bank #(.DEFAULTS(COEF_RESET)) u_bank (
    .clk(clk), .rst_n(rst_n), .lock(busy || sample_stb),
    .we(cfg_we), .sel(cfg_sel), .data(cfg_data), .bank(bank)
  );

  adp_refmodel u_model (
    .clk(clk), .rst_n(rst_n), .step(step), .x_in(speed_cmd),
    .a0(bank[SEL_A0*CW +: CW]), .a1(bank[SEL_A1*CW +: CW]),
    .a2(bank[SEL_A2*CW +: CW]), .b1(bank[SEL_B1*CW +: CW]),
    .b2(bank[SEL_B2*CW +: CW]), .ym_next(ym_next), .ym_q(model_out)
  );

  adp_pid u_pid (
    .clk(clk), .rst_n(rst_n), .step(step), .ym(ym_next), .meas(speed_meas),
    .kp(bank[SEL_KP*CW +: CW]), .ki(bank[SEL_KI*CW +: CW]),
    .kd(bank[SEL_KD*CW +: CW]), .p_q(adapt_out)
  );

  adp_writer #(.MAXACT(MAXACT), .IDXW(IDXW)) u_wr (
    .clk(clk), .rst_n(rst_n), .start(step), .new_vld(act_vld),
    .new_idx(act_idx), .adapt(adapt_out), .rd_addr(cen_rd_addr),
    .rd_data(cen_rd_data), .wr_valid(cen_wr_valid), .wr_ready(cen_wr_ready),
    .wr_addr(cen_wr_addr), .wr_data(cen_wr_data), .busy(busy)
  );

  // R9: a strobe during the write phase leaves model and factor alone
  p_stb_busy_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && sample_stb |=> $stable(model_out) && $stable(adapt_out));
endmodule

// File: tb/adp_center_adapter_test.sv
module adp_center_adapter_test;
  localparam int NR = 49, MA = 4, IW = 6;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, sample_stb, cfg_we, busy, cen_wr_valid, cen_wr_ready;
  logic signed [15:0] speed_cmd, speed_meas, cfg_data, model_out, adapt_out, cen_rd_data, cen_wr_data;
  logic [MA-1:0] act_vld;
  logic [MA*IW-1:0] act_idx;
  logic [2:0] cfg_sel;
  logic [IW-1:0] cen_rd_addr, cen_wr_addr;

  adp_center_adapter uut (
    .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb), .speed_cmd(speed_cmd),
    .speed_meas(speed_meas), .act_vld(act_vld), .act_idx(act_idx),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data), .busy(busy),
    .model_out(model_out), .adapt_out(adapt_out), .cen_rd_addr(cen_rd_addr),
    .cen_rd_data(cen_rd_data), .cen_wr_valid(cen_wr_valid),
    .cen_wr_ready(cen_wr_ready), .cen_wr_addr(cen_wr_addr), .cen_wr_data(cen_wr_data)
  );

  // center table model
  logic signed [15:0] tbl [NR];
  assign cen_rd_data = tbl[cen_rd_addr];
  int n_obs;
  longint obs_addr [8], obs_data [8];
  always @(posedge clk) if (cen_wr_valid && cen_wr_ready) begin
    tbl[cen_wr_addr] <= cen_wr_data;
    if (n_obs < 8) begin obs_addr[n_obs] <= cen_wr_addr; obs_data[n_obs] <= cen_wr_data; end
    n_obs <= n_obs + 1;
  end

  int stall_mode = 0, cyc = 0;
  always @(negedge clk) begin
    cyc <= cyc + 1;
    cen_wr_ready <= (stall_mode == 0) || (stall_mode == 1 && (cyc % 3) == 2);
  end

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  task automatic chk(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // independent behavioural model
  longint mc [8];
  longint mx1, mx2, my1, my2, mye1, macc;
  logic [MA-1:0] mprev_vld;
  logic [MA*IW-1:0] mprev_idx;
  longint exp_tbl [NR];
  longint exp_ym, exp_p;
  int exp_n;
  longint exp_addr [8], exp_data [8];

  function automatic longint satl(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  task automatic model_step(longint x, longint meas, logic [MA-1:0] vld, logic [MA*IW-1:0] idx);
    longint s, ym, ye, dye, p, a, d;
    s = mc[0]*x + mc[1]*mx1 + mc[2]*mx2 - mc[3]*my1 - mc[4]*my2;
    ym = satl(s >>> 8);
    ye = satl(ym - meas);
    dye = ye - mye1;
    p = satl((mc[5]*ye + mc[6]*macc + mc[7]*dye) >>> 8);
    macc = satl(macc + ye);
    mye1 = ye; mx2 = mx1; mx1 = x; my2 = my1; my1 = ym;
    exp_ym = ym; exp_p = p; exp_n = 0;
    for (int i = 0; i < MA; i++) if (mprev_vld[i]) begin
      a = longint'(mprev_idx[i*IW +: IW]);
      d = satl(exp_tbl[a] + p);
      exp_tbl[a] = d; exp_addr[exp_n] = a; exp_data[exp_n] = d; exp_n++;
    end
    mprev_vld = vld; mprev_idx = idx;
  endtask

  task automatic wait_idle();
    int t = 0;
    while (busy && t < 2000) begin @(negedge clk); t++; end
  endtask

  task automatic start_step(longint x, longint meas, logic [MA-1:0] vld, logic [MA*IW-1:0] idx, int stall);
    @(negedge clk);
    speed_cmd = 16'(x); speed_meas = 16'(meas); act_vld = vld; act_idx = idx;
    stall_mode = stall; n_obs = 0; sample_stb = 1'b1;
    @(negedge clk);
    sample_stb = 1'b0;
    model_step(x, meas, vld, idx);
  endtask

  task automatic check_step();
    int bad = 0;
    chk(model_out == exp_ym, "R2 model_out", model_out, exp_ym);
    chk(adapt_out == exp_p, "R3 adapt_out", adapt_out, exp_p);
    chk(n_obs == exp_n, "R5 write count", n_obs, exp_n);
    for (int i = 0; i < exp_n && i < n_obs; i++) begin
      chk(obs_addr[i] == exp_addr[i], "R6 write order", obs_addr[i], exp_addr[i]);
      chk(obs_data[i] == exp_data[i], "R6 write data", obs_data[i], exp_data[i]);
    end
    for (int i = 0; i < NR; i++) if (longint'(tbl[i]) != exp_tbl[i]) bad++;
    chk(bad == 0, "R5 untouched centers", bad, 0);
  endtask

  task automatic do_step(longint x, longint meas, logic [MA-1:0] vld, logic [MA*IW-1:0] idx, int stall);
    start_step(x, meas, vld, idx, stall);
    wait_idle();
    check_step();
  endtask

  task automatic load(int sel, longint val, bit accepted);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 3'(sel); cfg_data = 16'(val);
    @(negedge clk);
    cfg_we = 1'b0;
    if (accepted) mc[sel] = val;
  endtask

  // {cmd, meas, vld, idx3, idx2, idx1, idx0, stall}
  localparam logic [60:0] VEC [8] = '{
    {16'h03E8, 16'h0000, 4'b0011, 6'd0,  6'd0,  6'd5,  6'd3,  1'b0},
    {16'h04B0, 16'h0032, 4'b1111, 6'd11, 6'd10, 6'd4,  6'd3,  1'b1},
    {16'hFE0C, 16'h0190, 4'b0101, 6'd0,  6'd21, 6'd0,  6'd20, 1'b0},
    {16'h0000, 16'hFED4, 4'b1000, 6'd48, 6'd0,  6'd0,  6'd0,  1'b1},
    {16'h07D0, 16'h05DC, 4'b0000, 6'd0,  6'd0,  6'd0,  6'd0,  1'b0},
    {16'h07D0, 16'h076C, 4'b0110, 6'd0,  6'd8,  6'd7,  6'd0,  1'b1},
    {16'hFA24, 16'hFA88, 4'b1111, 6'd48, 6'd47, 6'd41, 6'd40, 1'b0},
    {16'h012C, 16'h00FA, 4'b0001, 6'd0,  6'd0,  6'd0,  6'd12, 1'b0}
  };

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [6:0] a_held;
    rst_n = 0; sample_stb = 0; cfg_we = 0; cfg_sel = 0; cfg_data = 0;
    speed_cmd = 0; speed_meas = 0; act_vld = 0; act_idx = 0; n_obs = 0;
    for (int i = 0; i < NR; i++) begin tbl[i] = 16'(i * 100 - 2400); exp_tbl[i] = i * 100 - 2400; end
    mc = '{2, 4, 2, -417, 170, 998, 1708, 146};
    mx1 = 0; mx2 = 0; my1 = 0; my2 = 0; mye1 = 0; macc = 0; mprev_vld = 0; mprev_idx = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 0, "R1 busy", busy, 0);
    chk(model_out == 0, "R1 model_out", model_out, 0);
    chk(adapt_out == 0, "R1 adapt_out", adapt_out, 0);
    chk(cen_wr_valid == 0, "R1 wr_valid", cen_wr_valid, 0);

    // R10 default coefficients; R5 first strobe writes nothing
    do_step(1000, 0, 4'b0011, {6'd0, 6'd0, 6'd5, 6'd3}, 0);
    chk(n_obs == 0, "R5 first strobe no write", n_obs, 0);
    do_step(800, 100, 4'b0000, '0, 0);
    chk(adapt_out == exp_p, "R10 default gains", adapt_out, exp_p);

    // R8 idle loads
    load(0, 64, 1); load(1, 64, 1); load(2, 64, 1); load(3, -96, 1);
    load(4, 32, 1); load(5, 300, 1); load(6, 40, 1); load(7, 100, 1);

    // vector walk
    for (int v = 0; v < 8; v++) begin
      do_step(longint'($signed(VEC[v][60:45])), longint'($signed(VEC[v][44:29])),
              VEC[v][28:25], VEC[v][24:1], VEC[v][0] ? 1 : 0);
    end

    // R7 / R8 / R9: write phase held by back-pressure
    start_step(500, 100, 4'b0000, '0, 2);
    @(negedge clk);
    a_held = {1'b0, cen_wr_addr};
    @(negedge clk);
    chk(cen_wr_valid == 1, "R7 valid held", cen_wr_valid, 1);
    chk(cen_wr_addr == a_held[5:0], "R7 addr held", cen_wr_addr, a_held);
    load(5, 0, 0);                       // ignored while busy
    @(negedge clk);
    sample_stb = 1'b1; speed_cmd = 16'sd9999;
    @(negedge clk);
    sample_stb = 1'b0;
    @(negedge clk);
    chk(model_out == exp_ym, "R9 model unchanged", model_out, exp_ym);
    chk(adapt_out == exp_p, "R9 adapt unchanged", adapt_out, exp_p);
    chk(busy == 1, "R9 still busy", busy, 1);
    stall_mode = 0;
    wait_idle();
    check_step();

    // R8: write in the same cycle as an accepted strobe is ignored
    @(negedge clk);
    speed_cmd = 16'sd1500; speed_meas = -16'sd200; act_vld = 4'b1111;
    act_idx = {6'd33, 6'd2, 6'd1, 6'd0}; n_obs = 0;
    sample_stb = 1'b1; cfg_we = 1'b1; cfg_sel = 3'd5; cfg_data = 16'sd0;
    @(negedge clk);
    sample_stb = 1'b0; cfg_we = 1'b0;
    model_step(1500, -200, 4'b1111, {6'd33, 6'd2, 6'd1, 6'd0});
    wait_idle();
    chk(adapt_out == exp_p, "R8 gain kept on strobe cycle", adapt_out, exp_p);
    check_step();

    // R4 / R6 saturation
    load(0, 256, 1); load(1, 0, 1); load(2, 0, 1); load(3, 0, 1);
    load(4, 0, 1); load(5, 0, 1); load(6, 256, 1); load(7, 0, 1);
    @(negedge clk);
    tbl[30] = 16'sd32000; exp_tbl[30] = 32000;
    for (int k = 0; k < 4; k++) do_step(30000, -30000, 4'b0001, {18'd0, 6'd30}, 0);
    chk(adapt_out == 32767, "R4 sum clamps high", adapt_out, 32767);
    do_step(-30000, 30000, 4'b0001, {18'd0, 6'd30}, 0);
    chk(tbl[30] == 32767, "R6 center clamps high", tbl[30], 32767);
    do_step(-30000, 30000, 4'b0001, {18'd0, 6'd30}, 0);
    chk(adapt_out == -1, "R4 sum after clamp", adapt_out, -1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule